// File: doc/BRIEF.md
# Comparator Timeout Guard with Pseudo-Random Fallback

This block sits between a dynamic comparator and a self-timed successive-approximation sequencer. It watches the comparator's enable and its two outputs. Both outputs rest high while the comparator is held in reset, and a genuine decision shows up as exactly one of them dropping low. When that happens the guard emits a one-cycle completion strobe together with the decided bit, and the sequencer can move on to the next bit.

A comparator that sits near its balance point can stay undecided for an unbounded time, and a self-timed loop would then stall. The guard therefore counts system-clock cycles from the moment it sees the enable high. The limit comes from a 6-bit value captured during reset and is chosen a little below the longest decision time the conversion can tolerate. If the limit runs out with no decision, the guard forces completion anyway. In that case the bit comes from a 7-bit maximal-length pseudo-random generator, since the remaining input is smaller than one LSB and either value is acceptable. A counter of forced completions is brought out for visibility.

The control is a three-state machine. IDLE waits for the enable. ARMED watches for a decision and for the timeout. DONE holds after a completion until the enable falls. The transitions are: IDLE to ARMED on enable high (start). ARMED to DONE on a valid decision (decide) or on timeout (force). ARMED to IDLE on enable low (abort). DONE to IDLE on enable low (release).

Top module: `cmp_timeout_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, done is 0, bit_out is 0 and forced_cnt is 0.
- R2: An output pair of 11 (both high) or 00 (both low) is not a decision, and it produces no strobe before the timeout.
- R3: Let E0 be the clock edge at which cmp_en is first sampled high. If cmp_en stays high and the first valid pair (01 or 10) is sampled at edge Ek with 1 <= k <= T, then done is high for the one cycle after Ek, and bit_out equals the cmp_outp value sampled at Ek (pair 10 gives 1, pair 01 gives 0).
- R4: T is the captured limit, or 1 when the limit is 0. If none of the edges E1..ET samples a valid pair, done is high for the one cycle after ET. A valid pair sampled at ET takes priority over the timeout.
- R5: The forced bit is bit 6 of a 7-bit generator state s. The state starts at 0000001 after reset and, only on a forced completion, advances to {s[5:0], s[6]^s[5]}.
- R6: done lasts one cycle and occurs at most once per enable-high period. Decisions sampled after a completion are ignored until cmp_en falls and rises again. bit_out changes only in a strobe cycle.
- R7: If cmp_en falls before any completion, there is no strobe, and neither the generator nor forced_cnt changes.
- R8: forced_cnt increments by one with each forced completion, changes at no other time, and wraps modulo 2^CNT_W.
- R9: The limit is taken from cfg_timeout only while rst_n is low. Changes to cfg_timeout after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the timeout limit is captured while it is low |
| cfg_timeout | input | TW (6) | Timeout limit in clock cycles |
| cmp_en | input | 1 | Comparator enable; high means comparing |
| cmp_outp | input | 1 | Comparator positive output, high while idle |
| cmp_outn | input | 1 | Comparator negative output, high while idle |
| done | output | 1 | One-cycle completion strobe |
| bit_out | output | 1 | Decided or forced bit, held between strobes |
| forced_cnt | output | CNT_W (8) | Count of forced completions |

## Verification
The assertions assume that the comparator inputs and the enable are synchronous to clk and stable around each rising edge. They also assume that a period of enable high begins from the idle state, with a low enable sampled in between. The bench drives every input on the falling edge and always returns the enable low, with both outputs high, for at least two cycles between comparisons. Within those bounds it covers decisions on the first sample, mid-window and on the last sample, a 00 pair, late decisions after a forced completion, aborted windows, and a long run of forced completions that wraps the counter and runs through the generator's full period.

// File: rtl/gtd_pkg.sv
package gtd_pkg;
    typedef enum logic [1:0] {
        G_IDLE  = 2'd0,
        G_ARMED = 2'd1,
        G_DONE  = 2'd2
    } gtd_state_e;

    localparam int unsigned GEN_W    = 7;
    localparam int unsigned GEN_TAPA = 6;
    localparam int unsigned GEN_TAPB = 5;
endpackage

// File: rtl/gtd_lfsr.sv
module gtd_lfsr #(
    parameter int unsigned W    = 7,
    parameter int unsigned TAPA = 6,
    parameter int unsigned TAPB = 5,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic rnd_bit
);
    logic [W-1:0] s_q;
    logic [W-1:0] s_d;

    // Shift chain: each stage takes its lower neighbour
    assign s_d[0] = s_q[TAPA] ^ s_q[TAPB];
    for (genvar i = 1; i < W; i++) begin : g_shift
        assign s_d[i] = s_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= SEED;
        else if (step)
            s_q <= s_d;
    end

    assign rnd_bit = s_q[W-1];
endmodule

// File: rtl/gtd_timer.sv
module gtd_timer #(
    parameter int unsigned TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cfg_limit,
    input  logic          run,
    output logic          expire
);
    logic [TW-1:0] lim_q;
    logic [TW-1:0] cnt_q;
    logic [TW:0]   lim_eff;
    logic [TW:0]   cnt_nxt;

    // Limit is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= cfg_limit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expire)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        lim_eff = (lim_q == '0) ? (TW+1)'(1) : {1'b0, lim_q};
        cnt_nxt = {1'b0, cnt_q} + 1'b1;
        expire  = run && (cnt_nxt >= lim_eff);
    end
endmodule

// File: rtl/cmp_timeout_guard.sv
module cmp_timeout_guard
    import gtd_pkg::*;
#(
    parameter int unsigned TW    = 6,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    cfg_timeout,
    input  logic             cmp_en,
    input  logic             cmp_outp,
    input  logic             cmp_outn,
    output logic             done,
    output logic             bit_out,
    output logic [CNT_W-1:0] forced_cnt
);
    gtd_state_e state_q;
    gtd_state_e state_d;
    logic       valid_dec;
    logic       take_real;
    logic       take_forced;
    logic       expire;
    logic       rnd_bit;

    // Exactly one output low marks a real decision
    assign valid_dec = cmp_outp ^ cmp_outn;

    gtd_timer #(.TW(TW)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_limit (cfg_timeout),
        .run       (state_q == G_ARMED),
        .expire    (expire)
    );

    gtd_lfsr #(
        .W    (GEN_W),
        .TAPA (GEN_TAPA),
        .TAPB (GEN_TAPB),
        .SEED (GEN_W'(1))
    ) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (take_forced),
        .rnd_bit (rnd_bit)
    );

    // Next-state and completion decode
    always_comb begin
        state_d     = state_q;
        take_real   = 1'b0;
        take_forced = 1'b0;
        unique case (state_q)
            G_IDLE: begin
                if (cmp_en)
                    state_d = G_ARMED;           // start
            end
            G_ARMED: begin
                if (!cmp_en) begin
                    state_d = G_IDLE;            // abort
                end else if (valid_dec) begin
                    state_d   = G_DONE;          // decide
                    take_real = 1'b1;
                end else if (expire) begin
                    state_d     = G_DONE;        // force
                    take_forced = 1'b1;
                end
            end
            G_DONE: begin
                if (!cmp_en)
                    state_d = G_IDLE;            // release
            end
            default: state_d = G_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= G_IDLE;
        else
            state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            bit_out    <= 1'b0;
            forced_cnt <= '0;
        end else begin
            done <= take_real | take_forced;
            if (take_real)
                bit_out <= cmp_outp;
            else if (take_forced)
                bit_out <= rnd_bit;
            if (take_forced)
                forced_cnt <= forced_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gtd_chk.sv
module gtd_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_en,
    input logic             cmp_outp,
    input logic             cmp_outn,
    input logic             done,
    input logic             bit_out,
    input logic [CNT_W-1:0] forced_cnt
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (!cmp_en)
            seen_q <= 1'b0;
        else if (done)
            seen_q <= 1'b1;
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    one_per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !seen_q);

    // R3
    real_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(cmp_outp != cmp_outn)) |-> (bit_out == $past(cmp_outp)));

    // R7
    done_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmp_en));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (forced_cnt != $past(forced_cnt)) |->
            (done && (forced_cnt == CNT_W'($past(forced_cnt) + 1'b1))));

    // R6
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_out != $past(bit_out)) |-> done);
endmodule

bind cmp_timeout_guard gtd_chk #(.CNT_W(CNT_W)) i_gtd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_en     (cmp_en),
    .cmp_outp   (cmp_outp),
    .cmp_outn   (cmp_outn),
    .done       (done),
    .bit_out    (bit_out),
    .forced_cnt (forced_cnt)
);

// File: tb/test_cmp_timeout_guard.sv
module test_cmp_timeout_guard;
    localparam int TW    = 6;
    localparam int CNT_W = 8;

    typedef struct packed {
        logic             b;
        logic [CNT_W-1:0] cnt;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TW-1:0]    cfg_timeout = '0;
    logic             cmp_en = 1'b0;
    logic             cmp_outp = 1'b1;
    logic             cmp_outn = 1'b1;
    logic             done;
    logic             bit_out;
    logic [CNT_W-1:0] forced_cnt;

    int n_chk = 0;
    int n_bad = 0;
    exp_t exp_q[$];
    logic [6:0]       gen_s;
    logic [CNT_W-1:0] exp_cnt;
    logic             last_bit;
    int               tlim;
    bit               finished = 0;

    always #5 clk = ~clk;

    cmp_timeout_guard #(.TW(TW), .CNT_W(CNT_W)) i_cmp_timeout_guard (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
        .cmp_en(cmp_en), .cmp_outp(cmp_outp), .cmp_outn(cmp_outn),
        .done(done), .bit_out(bit_out), .forced_cnt(forced_cnt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per strobe
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected strobe", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R3/R5 bit_out", {31'd0, bit_out}, {31'd0, e.b});
                check("R8 forced_cnt", {24'd0, forced_cnt}, {24'd0, e.cnt});
            end
        end
    end

    task automatic do_reset(input logic [TW-1:0] lim);
        rst_n = 1'b0;
        cfg_timeout = lim;
        cmp_en = 1'b0; cmp_outp = 1'b1; cmp_outn = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        gen_s = 7'b0000001;
        exp_cnt = '0;
        last_bit = 1'b0;
        tlim = (lim == 0) ? 1 : int'(lim);
    endtask

    // Driver: dec_at = sample index of the pair, 0 = none
    task automatic run_op(input int dec_at, input logic [1:0] pair, input string tag);
        bit   real_dec;
        exp_t e;
        real_dec = (pair == 2'b10 || pair == 2'b01) && dec_at >= 1 && dec_at <= tlim;
        if (real_dec) begin
            e.b = pair[1];
        end else begin
            e.b = gen_s[6];
            gen_s = {gen_s[5:0], gen_s[6] ^ gen_s[5]};
            exp_cnt = exp_cnt + 1'b1;
        end
        e.cnt = exp_cnt;
        last_bit = e.b;
        exp_q.push_back(e);
        @(negedge clk);
        cmp_en = 1'b1;
        if (dec_at > 0) begin
            repeat (dec_at) @(negedge clk);
            {cmp_outp, cmp_outn} = pair;
        end
        repeat (tlim + 4) @(negedge clk);
        #1;
        check({tag, " strobe count"}, exp_q.size(), 0);
        check({"R6 held bit ", tag}, {31'd0, bit_out}, {31'd0, last_bit});
        cmp_en = 1'b0; cmp_outp = 1'b1; cmp_outn = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_abort(input int n);
        @(negedge clk);
        cmp_en = 1'b1;
        repeat (n) @(negedge clk);
        cmp_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R7 abort no strobe", exp_q.size(), 0);
        check("R7 abort cnt", {24'd0, forced_cnt}, {24'd0, exp_cnt});
    endtask

    initial begin
        do_reset(6'd5);
        #1;
        check("R1 done", {31'd0, done}, 0);
        check("R1 bit_out", {31'd0, bit_out}, 0);
        check("R1 forced_cnt", {24'd0, forced_cnt}, 0);

        run_op(1, 2'b10, "R3 first sample 1");
        run_op(3, 2'b01, "R3 mid sample 0");
        run_op(5, 2'b10, "R4 last sample wins");
        run_op(0, 2'b11, "R4 plain timeout");
        run_op(2, 2'b00, "R2 both low");
        run_op(7, 2'b01, "R6 late decision");
        run_abort(3);
        run_op(0, 2'b11, "R5 after abort");
        run_op(2, 2'b01, "R3 after forced");

        do_reset(6'd0);
        cfg_timeout = 6'd40;
        run_op(0, 2'b11, "R9 limit kept");
        run_op(1, 2'b10, "R4 T1 decision wins");
        for (int i = 0; i < 260; i++)
            run_op(0, 2'b11, "R8 wrap run");
        check("R8 final count", {24'd0, forced_cnt}, {24'd0, exp_cnt});

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule